// File: doc/BRIEF.md
# I2C SCL Clock Synchronization Generator

This block produces the serial clock for a two-wire bus master whose clock wire is shared and wired-AND: any device may pull the line low, and nobody drives it high. The block pulls the line low through an open-drain enable, counts a programmable number of system cycles, and then lets go. It does not count its high time until it actually sees the line high. This means a device with a longer low time, or a slave that stretches the clock, simply holds the block in a high-wait state. If another device pulls the line low while the block is counting high time, the block drops its high count at once and starts a new low period.

Each request produces one byte-plus-acknowledge burst of exactly nine clock pulses. When the ninth high phase ends, the block gives a one-cycle completion pulse. It then keeps the line low, ready for the next byte, until either a new request arrives or a release command lets the line go. A release command given during a burst ends the burst and reports completion. The burst is never retried.

Top module: `scl_sync_gen`

## Requirements
- R1: `scl_oe` = 1 means pull the line low and `scl_oe` = 0 means release it. The block has no way to drive the line high. After reset `scl_oe`, `busy` and `done` are 0.
- R2: A request accepted while idle or holding starts a low phase. `scl_oe` is 1 for exactly `low_cnt` cycles, and the value is taken when the phase starts.
- R3: When the low count ends, `scl_oe` goes to 0. For as long as `scl_in` stays low, the block stays released and counts nothing, with no time limit.
- R4: The high count starts at the first clock edge that samples `scl_in` high. The block stays released for `high_cnt` cycles after that edge and then pulls low. On a free line, each pulse is therefore `low_cnt` cycles with `scl_oe` = 1 followed by `high_cnt`+1 cycles with `scl_oe` = 0.
- R5: If `scl_in` is sampled low during a high count, `scl_oe` is 1 from the next cycle and a full low count starts.
- R6: One request gives exactly nine high phases. `done` is 1 for one cycle, in the first cycle after the ninth high phase ends. In that same cycle `busy` falls and `scl_oe` is 1. `busy` is 1 at all other times during the burst.
- R7: After a completed burst, `scl_oe` stays 1 whatever `scl_in` does. A request then starts a new burst at once. A `release_req` alone sets `scl_oe` and `busy` to 0 in the next cycle and does not pulse `done`. A request takes priority over a release given in the same cycle.
- R8: A `release_req` during a burst gives, in the next cycle, `scl_oe` = 0, `busy` = 0 and a one-cycle `done`. The block then stays idle and does not restart the burst.
- R9: While idle, `scl_in` edges and `release_req` have no effect on the outputs. A request received during a burst is ignored.
- R10: A `low_cnt` or `high_cnt` value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_req | input | 1 | Start a nine-pulse burst (sampled when idle or holding) |
| release_req | input | 1 | Release the line: ends a burst or leaves the holding state |
| low_cnt | input | 16 | Low period in system cycles |
| high_cnt | input | 16 | High period in system cycles |
| scl_in | input | 1 | Sensed clock line level, already synchronized |
| scl_oe | output | 1 | Open-drain pull-low enable for the clock line |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse when a burst completes or is aborted |

## Verification
Two states are hard to reach from the ports. The first is a long high-wait. The second is a high count cut short by another device, because on a free line the block's own release always makes the line high one cycle later. The bench models the wired-AND line as the block's enable ORed with a second, bench-driven pull-down. It watches for the first sample where the block has released the line and asserts the external pull-down on that same cycle, which holds the block in high-wait for many cycles. It also asserts the pull-down a few cycles into a long high count, which tests the restart of the low count. A sweep over small low and high values, including values below the minimum, checks the exact per-cycle enable pattern of every burst.

// File: rtl/scl_sync_pkg.sv
package scl_sync_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HWAIT = 3'd2,
    ST_HIGH  = 3'd3,
    ST_HOLD  = 3'd4
  } scl_state_e;

  // Raise a requested period to the allowed floor.
  function automatic int unsigned eff_period(input int unsigned raw,
                                             input int unsigned floor_v);
    return (raw < floor_v) ? floor_v : raw;
  endfunction

  // System cycles of one full pulse on a free line: low, one sense cycle, high.
  function automatic int unsigned pulse_cycles(input int unsigned low_v,
                                               input int unsigned high_v,
                                               input int unsigned floor_v);
    return eff_period(low_v, floor_v) + eff_period(high_v, floor_v) + 1;
  endfunction

  // True when a state keeps the line pulled low.
  function automatic logic pulls_low(input scl_state_e st);
    return (st == ST_LOW) || (st == ST_HOLD);
  endfunction

  // True while a burst is in flight.
  function automatic logic in_burst(input scl_state_e st);
    return (st == ST_LOW) || (st == ST_HWAIT) || (st == ST_HIGH);
  endfunction

endpackage

// File: rtl/scl_period_cnt.sv
module scl_period_cnt
  import scl_sync_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int MIN_PERIOD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] raw_period,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(eff_period(32'(raw_period), MIN_PERIOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // The phase has lasted its full count in the cycle where one remains.
  assign expire = run && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/scl_pulse_cnt.sv
module scl_pulse_cnt #(
  parameter int PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);

  localparam int IDX_W = (PULSES > 1) ? $clog2(PULSES) : 1;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (clear) begin
      idx_q <= '0;
    end else if (step && !last) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign last = (idx_q == IDX_W'(PULSES - 1));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_req,
  input  logic       release_req,
  input  logic       scl_in,
  input  logic       cnt_expire,
  input  logic       pulse_last,
  output scl_state_e state,
  output logic       load_low,
  output logic       load_high,
  output logic       cnt_run,
  output logic       pulse_clear,
  output logic       pulse_step,
  output logic       start_evt,
  output logic       low_done,
  output logic       line_high_seen,
  output logic       high_cut,
  output logic       byte_end,
  output logic       abort_evt,
  output logic       scl_oe,
  output logic       busy,
  output logic       done
);

  scl_state_e state_q, state_d;
  logic       oe_q;
  logic       done_q;
  logic       high_end;

  always_comb begin
    state_d        = state_q;
    start_evt      = 1'b0;
    low_done       = 1'b0;
    line_high_seen = 1'b0;
    high_end       = 1'b0;
    high_cut       = 1'b0;
    byte_end       = 1'b0;
    abort_evt      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (xfer_req) begin
          start_evt = 1'b1;
          state_d   = ST_LOW;
        end
      end
      ST_LOW: begin
        if (release_req) begin
          abort_evt = 1'b1;
          state_d   = ST_IDLE;
        end else if (cnt_expire) begin
          low_done = 1'b1;
          state_d  = ST_HWAIT;
        end
      end
      ST_HWAIT: begin
        if (release_req) begin
          abort_evt = 1'b1;
          state_d   = ST_IDLE;
        end else if (scl_in) begin
          line_high_seen = 1'b1;
          state_d        = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (release_req) begin
          abort_evt = 1'b1;
          state_d   = ST_IDLE;
        end else if (!scl_in || cnt_expire) begin
          high_end = 1'b1;
          high_cut = !scl_in;
          if (pulse_last) begin
            byte_end = 1'b1;
            state_d  = ST_HOLD;
          end else begin
            state_d  = ST_LOW;
          end
        end
      end
      ST_HOLD: begin
        if (xfer_req) begin
          start_evt = 1'b1;
          state_d   = ST_LOW;
        end else if (release_req) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign load_low    = start_evt || (high_end && !pulse_last);
  assign load_high   = line_high_seen;
  assign cnt_run     = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign pulse_clear = start_evt;
  assign pulse_step  = high_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      oe_q    <= pulls_low(state_d);
      done_q  <= byte_end || abort_evt;
    end
  end

  assign state  = state_q;
  assign scl_oe = oe_q;
  assign busy   = in_burst(state_q);
  assign done   = done_q;

endmodule

// File: rtl/scl_sync_gen.sv
module scl_sync_gen
  import scl_sync_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PULSES     = 9,
  parameter int MIN_PERIOD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_req,
  input  logic             release_req,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             busy,
  output logic             done
);

  scl_state_e       state_q;
  logic             load_low;
  logic             load_high;
  logic             cnt_run;
  logic             cnt_expire;
  logic             pulse_clear;
  logic             pulse_step;
  logic             pulse_last;
  logic             start_evt;
  logic             low_done;
  logic             line_high_seen;
  logic             high_cut;
  logic             byte_end;
  logic             abort_evt;
  logic [CNT_W-1:0] period_sel;

  // Low and high phases never overlap, so one counter serves both.
  assign period_sel = load_high ? high_cnt : low_cnt;

  scl_period_cnt #(
    .CNT_W      (CNT_W),
    .MIN_PERIOD (MIN_PERIOD)
  ) i_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_low || load_high),
    .run        (cnt_run),
    .raw_period (period_sel),
    .expire     (cnt_expire)
  );

  scl_pulse_cnt #(
    .PULSES (PULSES)
  ) i_pulses (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (pulse_clear),
    .step  (pulse_step),
    .last  (pulse_last)
  );

  scl_phase_fsm i_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .xfer_req       (xfer_req),
    .release_req    (release_req),
    .scl_in         (scl_in),
    .cnt_expire     (cnt_expire),
    .pulse_last     (pulse_last),
    .state          (state_q),
    .load_low       (load_low),
    .load_high      (load_high),
    .cnt_run        (cnt_run),
    .pulse_clear    (pulse_clear),
    .pulse_step     (pulse_step),
    .start_evt      (start_evt),
    .low_done       (low_done),
    .line_high_seen (line_high_seen),
    .high_cut       (high_cut),
    .byte_end       (byte_end),
    .abort_evt      (abort_evt),
    .scl_oe         (scl_oe),
    .busy           (busy),
    .done           (done)
  );

endmodule

// File: rtl/scl_sync_chk.sv
module scl_sync_chk
  import scl_sync_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_req,
  input logic       release_req,
  input logic       scl_in,
  input logic       scl_oe,
  input logic       busy,
  input logic       done,
  input scl_state_e state,
  input logic       low_done,
  input logic       high_cut,
  input logic       byte_end
);

  // R1: an idle block never pulls the line
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !scl_oe);

  // R3: the end of the low count releases the line
  assert_low_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    low_done |=> (!scl_oe && (state == ST_HWAIT)));

  // R3: a line held low keeps the block waiting, released
  assert_stretch_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HWAIT) && !scl_in && !release_req) |=> ((state == ST_HWAIT) && !scl_oe));

  // R5: another device pulling low during the high count restarts the low phase
  assert_cut_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_HIGH) && !scl_in && !release_req) |=> scl_oe);

  // R5: internal cut event appears only when the line is low
  assert_cut_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    high_cut |-> !scl_in);

  // R6: completion is a single-cycle pulse outside a burst
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: the end of the ninth pulse leaves the line held low with completion
  assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (scl_oe && done && !busy));

  // R8: release during a burst aborts it
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && release_req) |=> (!scl_oe && !busy && done));

  // R9: idle without a request stays idle
  assert_idle_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !xfer_req) |=> ((state == ST_IDLE) && !scl_oe && !busy));

endmodule

bind scl_sync_gen scl_sync_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_req    (xfer_req),
  .release_req (release_req),
  .scl_in      (scl_in),
  .scl_oe      (scl_oe),
  .busy        (busy),
  .done        (done),
  .state       (state_q),
  .low_done    (low_done),
  .high_cut    (high_cut),
  .byte_end    (byte_end)
);

// File: tb/test_scl_sync_gen.sv
`timescale 1ns/1ps
module test_scl_sync_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_req = 1'b0;
  logic        release_req = 1'b0;
  logic [15:0] low_cnt = 16'd3;
  logic [15:0] high_cnt = 16'd3;
  logic        ext_pull = 1'b0;
  logic        scl_in;
  logic        scl_oe;
  logic        busy;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  // Wired-AND clock line: low if the block or the other device pulls it.
  assign scl_in = ~(scl_oe | ext_pull);

  scl_sync_gen i_scl_sync_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_req    (xfer_req),
    .release_req (release_req),
    .low_cnt     (low_cnt),
    .high_cnt    (high_cnt),
    .scl_in      (scl_in),
    .scl_oe      (scl_oe),
    .busy        (busy),
    .done        (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int floor2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  // One burst; pattern expected per sample k after the request edge.
  task automatic run_byte(input int l, input int h, input bit poke);
    int le, he, per, total, mism, first_bad, busy_bad;
    le = floor2(l); he = floor2(h); per = le + he + 1; total = 9 * per;
    mism = 0; first_bad = 0; busy_bad = 0;
    @(negedge clk);
    low_cnt = 16'(l); high_cnt = 16'(h); xfer_req = 1'b1;
    for (int k = 1; k <= total; k++) begin
      @(negedge clk);
      if (scl_oe !== (((k - 1) % per) < le)) begin
        mism++;
        if (first_bad == 0) first_bad = k;
      end
      if (!busy || done) busy_bad++;
      if (k == 1) xfer_req = 1'b0;
      if (poke && k == 7) xfer_req = 1'b1;   // R9: request while busy
      if (poke && k == 8) xfer_req = 1'b0;
    end
    check(mism == 0, (l < 2 || h < 2) ? "R10" : "R2/R4",
          $sformatf("pulse pattern L=%0d H=%0d first bad sample", l, h), first_bad, 0);
    check(busy_bad == 0, "R6", "busy low or done during burst", busy_bad, 0);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0 && scl_oe === 1'b1, "R6",
          "done/busy/oe after ninth pulse", {done, busy, scl_oe}, 3'b101);
    @(negedge clk);
    check(done === 1'b0 && scl_oe === 1'b1, "R7", "hold after done",
          {done, scl_oe}, 2'b01);
  endtask

  task automatic release_idle();
    @(negedge clk); release_req = 1'b1;
    @(negedge clk); release_req = 1'b0;
    check(scl_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "R7",
          "release from hold", {scl_oe, busy, done}, 0);
  endtask

  task automatic wait_released();
    do @(negedge clk); while (scl_oe !== 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    if (1) begin
      #1 check(scl_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "R1",
               "outputs in reset", {scl_oe, busy, done}, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(scl_oe === 1'b0 && busy === 1'b0, "R1", "idle after reset", {scl_oe, busy}, 0);

    // R9: idle ignores line edges and release
    begin
      int bad = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (scl_oe || busy || done) bad++;
        ext_pull = k[0];
        release_req = (k % 3 == 0);
      end
      ext_pull = 1'b0; release_req = 1'b0;
      @(negedge clk);
      if (scl_oe || busy || done) bad++;
      check(bad == 0, "R9", "idle disturbed by line or release", bad, 0);
    end

    // R2 R4 R10: sweep of low/high settings including values below the floor
    for (int l = 0; l <= 5; l++) begin
      for (int h = 0; h <= 4; h++) begin
        run_byte(l, h, ((l + h) % 2) == 1);
        release_idle();
      end
    end

    // R7: hold ignores the line, then a back-to-back byte
    run_byte(3, 2, 1'b0);
    begin
      int bad = 0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (!scl_oe || busy || done) bad++;
        ext_pull = k[1];
      end
      ext_pull = 1'b0;
      check(bad == 0, "R7", "hold disturbed", bad, 0);
    end
    run_byte(4, 3, 1'b0);
    // R7: request beats release in the same cycle
    @(negedge clk); xfer_req = 1'b1; release_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0; release_req = 1'b0;
    check(busy === 1'b1 && scl_oe === 1'b1, "R7", "request priority over release",
          {busy, scl_oe}, 2'b11);
    // R8: abort from a low phase
    @(negedge clk); release_req = 1'b1;
    @(negedge clk); release_req = 1'b0;
    check(scl_oe === 1'b0 && busy === 1'b0 && done === 1'b1, "R8",
          "abort response", {scl_oe, busy, done}, 3'b001);
    begin
      int bad = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (scl_oe || busy || done) bad++;
      end
      check(bad == 0, "R8", "activity after abort (retry)", bad, 0);
    end

    // R3 R4: long stretch in high-wait, then high count from the line rise
    @(negedge clk); low_cnt = 16'd3; high_cnt = 16'd3; xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    wait_released();
    ext_pull = 1'b1;
    begin
      int bad = 0;
      int hi_n = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (scl_oe || !busy) bad++;
      end
      check(bad == 0, "R3", "stretch not honoured", bad, 0);
      ext_pull = 1'b0;
      @(negedge clk);
      while (scl_oe === 1'b0 && hi_n < 100) begin
        hi_n++;
        @(negedge clk);
      end
      check(hi_n == 3, "R4", "high cycles after line rise", hi_n, 3);
    end
    release_idle_abort();

    // R5: another device cuts the high phase short
    @(negedge clk); low_cnt = 16'd4; high_cnt = 16'd10; xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
    wait_released();
    repeat (3) @(negedge clk);
    ext_pull = 1'b1;
    @(negedge clk);
    ext_pull = 1'b0;
    begin
      int lo_n = 0;
      while (scl_oe === 1'b1 && lo_n < 100) begin
        lo_n++;
        @(negedge clk);
      end
      check(lo_n == 4, "R5", "low cycles after cut high phase", lo_n, 4);
    end
    release_idle_abort();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  task automatic release_idle_abort();
    @(negedge clk); release_req = 1'b1;
    @(negedge clk); release_req = 1'b0;
    check(scl_oe === 1'b0 && busy === 1'b0 && done === 1'b1, "R8",
          "abort mid-burst", {scl_oe, busy, done}, 3'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule